// File: doc/BRIEF.md
# Sixteen-Bit Variable Shift and Rotate Unit

This block takes a 16-bit operand together with an 8-bit count and a mode code, and produces the operand moved by the count. It can shift left with zero fill, or shift right in one of three ways: filling with copies of the top bit, with zeros, or with ones. It can also rotate left. The shift modes read only the low five bits of the count, so they accept counts from 0 to 31. The rotate mode reads only the low four bits. To rotate right by k places, a caller gives a left-rotate count of 16 minus k.

The operand enters through a valid/ready stream port, and the result leaves through one. The count travels with the result unchanged. An accepted request appears on the output exactly one clock later. The output register holds its contents while the consumer withholds `out_ready`. The input is ready whenever the output register is empty or is being drained in the same cycle. A transfer takes place on a rising edge where valid and ready are both high.

The shift is a logarithmic network with one stage per count bit. A right-shift network is shared by all three right-shift modes, which differ only in the fill bit. Rotation has its own four-stage network.

Top module: `bsh_shift_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0, `out_data` and `out_cnt` are 0, and `in_ready` is 1.
- R2: Mode code 0 shifts the operand left by `in_cnt[4:0]` places and fills with zeros. Counts of 16 or more give 0x0000.
- R3: Mode code 1 shifts right by `in_cnt[4:0]` places and fills every vacated bit with operand bit 15. Counts of 16 or more give sixteen copies of bit 15.
- R4: Mode code 2 shifts right by `in_cnt[4:0]` places with zero fill. Counts of 16 or more give 0x0000.
- R5: Mode code 3 shifts right by `in_cnt[4:0]` places with one fill. Counts of 16 or more give 0xFFFF.
- R6: In mode codes 0 to 3, `in_cnt[7:5]` has no effect on the result.
- R7: Mode code 4 rotates left by `in_cnt[3:0]` places, and bits leaving bit 15 re-enter at bit 0. `in_cnt[7:4]` has no effect. A count of 16-k therefore equals a right rotation by k, and a count of 0 returns the operand unchanged.
- R8: Mode codes 5, 6 and 7 pass the operand through unchanged.
- R9: `out_cnt` carries the accepted `in_cnt` with all eight bits unmodified.
- R10: A request accepted on one rising edge has `out_valid` high and its result on `out_data` after that same edge. The latency is one clock.
- R11: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data`/`out_cnt` hold. `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1. With no new request, a drained output makes `out_valid` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present on the input |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_mode | input | 3 | Operation code (0 shl, 1 sra, 2 srl, 3 one-fill right, 4 rotate left) |
| in_data | input | 16 | Operand |
| in_cnt | input | 8 | Shift or rotate count |
| out_valid | output | 1 | Result present on the output |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 16 | Shifted or rotated operand |
| out_cnt | output | 8 | Count that came with the request |

## Verification
Two things can happen on the same edge: the consumer drains the held result, and a new request is accepted into the register it leaves free. The bench provokes this in two ways. It stalls the output with a result held and a second request waiting, then raises `out_ready` while that request is still offered. It also streams requests back to back with the consumer always ready. The bench judges both cases by checking that every result appears exactly once and in order, with its own count. It also checks that the waiting request changed nothing on the output during the stall.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  // Operation codes carried on in_mode; 5..7 are pass-through.
  localparam logic [2:0] MODE_SHL = 3'd0;
  localparam logic [2:0] MODE_SRA = 3'd1;
  localparam logic [2:0] MODE_SRL = 3'd2;
  localparam logic [2:0] MODE_SRF = 3'd3;
  localparam logic [2:0] MODE_ROL = 3'd4;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_ONE  = 2'd1,
    FILL_SIGN = 2'd2
  } fill_kind_e;

endpackage

// File: rtl/bsh_shift_net.sv
// Logarithmic shift network: stage s moves the word by 2**s places when
// amt[s] is set. Vacated positions take the fill bit. Stages whose
// distance reaches the word width clear the whole word to fill.
module bsh_shift_net #(
  parameter int DATA_W   = 16,
  parameter int AMT_W    = 5,
  parameter bit DIR_LEFT = 1'b1
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  input  logic              fill,
  output logic [DATA_W-1:0] dout
);

  logic [AMT_W:0][DATA_W-1:0] stg;

  assign stg[0] = din;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int DIST = 1 << s;
    for (genvar j = 0; j < DATA_W; j++) begin : g_bit
      if (DIR_LEFT) begin : g_left
        if (j >= DIST) begin : g_move
          assign stg[s+1][j] = amt[s] ? stg[s][j-DIST] : stg[s][j];
        end else begin : g_fill
          assign stg[s+1][j] = amt[s] ? fill : stg[s][j];
        end
      end else begin : g_right
        if (j + DIST < DATA_W) begin : g_move
          assign stg[s+1][j] = amt[s] ? stg[s][j+DIST] : stg[s][j];
        end else begin : g_fill
          assign stg[s+1][j] = amt[s] ? fill : stg[s][j];
        end
      end
    end
  end

  assign dout = stg[AMT_W];

endmodule

// File: rtl/bsh_rotate_net.sv
// Left-rotate network: stage s rotates by 2**s places when amt[s] is set.
module bsh_rotate_net #(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 4
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] dout
);

  logic [AMT_W:0][DATA_W-1:0] stg;

  assign stg[0] = din;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int DIST = (1 << s) % DATA_W;
    for (genvar j = 0; j < DATA_W; j++) begin : g_bit
      localparam int SRC = (j + DATA_W - DIST) % DATA_W;
      assign stg[s+1][j] = amt[s] ? stg[s][SRC] : stg[s][j];
    end
  end

  assign dout = stg[AMT_W];

endmodule

// File: rtl/bsh_select.sv
// Picks the network output that matches the operation code and derives
// the fill bit for the shared right-shift network.
module bsh_select
  import bsh_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] shl_res,
  input  logic [DATA_W-1:0] shr_res,
  input  logic [DATA_W-1:0] rol_res,
  output logic              shr_fill,
  output logic [DATA_W-1:0] result
);

  fill_kind_e fill_kind;

  always_comb begin
    unique case (mode)
      MODE_SRA: fill_kind = FILL_SIGN;
      MODE_SRF: fill_kind = FILL_ONE;
      default:  fill_kind = FILL_ZERO;
    endcase
  end

  always_comb begin
    unique case (fill_kind)
      FILL_SIGN: shr_fill = operand[DATA_W-1];
      FILL_ONE:  shr_fill = 1'b1;
      default:   shr_fill = 1'b0;
    endcase
  end

  always_comb begin
    unique case (mode)
      MODE_SHL:                     result = shl_res;
      MODE_SRA, MODE_SRL, MODE_SRF: result = shr_res;
      MODE_ROL:                     result = rol_res;
      default:                      result = operand;
    endcase
  end

endmodule

// File: rtl/bsh_out_stage.sv
// Single output register with valid/ready flow control. It accepts a new
// entry whenever it is empty or is draining in the same cycle.
module bsh_out_stage #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_result,
  input  logic [CNT_W-1:0]  in_cnt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  out_cnt
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_cnt  <= '0;
    end else if (take) begin
      out_data <= in_result;
      out_cnt  <= in_cnt;
    end
  end

endmodule

// File: rtl/bsh_shift_unit.sv
module bsh_shift_unit #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_mode,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_cnt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  out_cnt
);

  // Shift counts span one bit more than a word index; rotation wraps.
  localparam int ROT_W = $clog2(DATA_W);
  localparam int SH_W  = ROT_W + 1;

  logic [DATA_W-1:0] shl_res;
  logic [DATA_W-1:0] shr_res;
  logic [DATA_W-1:0] rol_res;
  logic [DATA_W-1:0] result;
  logic              shr_fill;

  bsh_shift_net #(
    .DATA_W  (DATA_W),
    .AMT_W   (SH_W),
    .DIR_LEFT(1'b1)
  ) u_shl (
    .din (in_data),
    .amt (in_cnt[SH_W-1:0]),
    .fill(1'b0),
    .dout(shl_res)
  );

  bsh_shift_net #(
    .DATA_W  (DATA_W),
    .AMT_W   (SH_W),
    .DIR_LEFT(1'b0)
  ) u_shr (
    .din (in_data),
    .amt (in_cnt[SH_W-1:0]),
    .fill(shr_fill),
    .dout(shr_res)
  );

  bsh_rotate_net #(
    .DATA_W(DATA_W),
    .AMT_W (ROT_W)
  ) u_rol (
    .din (in_data),
    .amt (in_cnt[ROT_W-1:0]),
    .dout(rol_res)
  );

  bsh_select #(
    .DATA_W(DATA_W)
  ) u_sel (
    .mode    (in_mode),
    .operand (in_data),
    .shl_res (shl_res),
    .shr_res (shr_res),
    .rol_res (rol_res),
    .shr_fill(shr_fill),
    .result  (result)
  );

  bsh_out_stage #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_result(result),
    .in_cnt   (in_cnt),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_cnt  (out_cnt)
  );

endmodule

// File: rtl/bsh_checker.sv
module bsh_checker
  import bsh_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_mode,
  input logic [DATA_W-1:0] in_data,
  input logic [CNT_W-1:0]  in_cnt,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [CNT_W-1:0]  out_cnt
);

  localparam int ROT_W = $clog2(DATA_W);
  localparam int SH_W  = ROT_W + 1;

  logic acc;
  logic big_cnt;
  logic rot_zero;

  assign acc      = in_valid && in_ready;
  assign big_cnt  = (32'(in_cnt[SH_W-1:0]) >= DATA_W);
  assign rot_zero = (in_cnt[ROT_W-1:0] == '0);

  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  p_shl_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mode == MODE_SHL && big_cnt |=> out_data == '0);

  p_sra_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mode == MODE_SRA && big_cnt |=>
      out_data == {DATA_W{$past(in_data[DATA_W-1])}});

  p_srl_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mode == MODE_SRL && big_cnt |=> out_data == '0);

  p_srf_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mode == MODE_SRF && big_cnt |=> out_data == '1);

  p_rot_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mode == MODE_ROL && rot_zero |=> out_data == $past(in_data));

  p_reserved_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mode > MODE_ROL |=> out_data == $past(in_data));

  p_cnt_echo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_cnt == $past(in_cnt));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=>
      out_valid && $stable(out_data) && $stable(out_cnt));

  p_stall_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_ready_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid || out_ready |-> in_ready);

endmodule

bind bsh_shift_unit bsh_checker #(
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_mode  (in_mode),
  .in_data  (in_data),
  .in_cnt   (in_cnt),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_cnt  (out_cnt)
);

// File: tb/test_bsh_shift_unit.sv
`timescale 1ns/1ps
module test_bsh_shift_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = 3'd0;
  logic [15:0] in_data = 16'h0;
  logic [7:0]  in_cnt = 8'h0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic [7:0]  out_cnt;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  bsh_shift_unit i_bsh_shift_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_mode  (in_mode),
    .in_data  (in_data),
    .in_cnt   (in_cnt),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_cnt  (out_cnt)
  );

  // Reference: one-place moves repeated, built from the requirement text.
  function automatic logic [15:0] model(input logic [2:0] m,
                                        input logic [15:0] d,
                                        input logic [7:0] c);
    logic [15:0] r = d;
    int n = (m == 3'd4) ? int'(c[3:0]) : int'(c[4:0]);
    for (int i = 0; i < 32; i++) begin
      if (i < n) begin
        case (m)
          3'd0: r = {r[14:0], 1'b0};
          3'd1: r = {d[15], r[15:1]};
          3'd2: r = {1'b0, r[15:1]};
          3'd3: r = {1'b1, r[15:1]};
          3'd4: r = {r[14:0], r[15]};
          default: r = d;
        endcase
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One request, consumer always ready, result checked one clock later.
  task automatic xfer(input string req, input logic [2:0] m,
                      input logic [15:0] d, input logic [7:0] c);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_mode   = m;
    in_data   = d;
    in_cnt    = c;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R10 valid"}, 32'(out_valid), 32'd1);
    chk({req, " data"}, 32'(out_data), 32'(model(m, d, c)));
    chk({req, " R9 count"}, 32'(out_cnt), 32'(c));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1 out_data in reset", 32'(out_data), 32'd0);
    chk("R1 in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after release", 32'(out_valid), 32'd0);
    chk("R1 out_cnt after release", 32'(out_cnt), 32'd0);
  endtask

  task automatic t_shl;
    xfer("R2 shl 0", 3'd0, 16'hA5C3, 8'd0);
    xfer("R2 shl 3", 3'd0, 16'h8421, 8'd3);
    xfer("R2 shl 15", 3'd0, 16'h0003, 8'd15);
    xfer("R2 shl 16", 3'd0, 16'hFFFF, 8'd16);
    xfer("R2 shl 31", 3'd0, 16'h1234, 8'd31);
  endtask

  task automatic t_sra;
    xfer("R3 sra neg 4", 3'd1, 16'h8F00, 8'd4);
    xfer("R3 sra pos 4", 3'd1, 16'h7F00, 8'd4);
    xfer("R3 sra neg 16", 3'd1, 16'h8000, 8'd16);
    xfer("R3 sra pos 20", 3'd1, 16'h7FFF, 8'd20);
  endtask

  task automatic t_srl;
    xfer("R4 srl 1", 3'd2, 16'h8001, 8'd1);
    xfer("R4 srl 15", 3'd2, 16'hFFFF, 8'd15);
    xfer("R4 srl 16", 3'd2, 16'hFFFF, 8'd16);
  endtask

  task automatic t_srf;
    xfer("R5 srf 5", 3'd3, 16'h0000, 8'd5);
    xfer("R5 srf 9", 3'd3, 16'h8421, 8'd9);
    xfer("R5 srf 31", 3'd3, 16'h0000, 8'd31);
  endtask

  task automatic t_high_bits;
    xfer("R6 shl count 0xE2", 3'd0, 16'h00F1, 8'hE2);
    xfer("R6 srl count 0x25", 3'd2, 16'hF000, 8'h25);
    xfer("R6 sra count 0xA0", 3'd1, 16'h9000, 8'hA0);
  endtask

  task automatic t_rotate;
    xfer("R7 rol 1", 3'd4, 16'h8001, 8'd1);
    xfer("R7 rol 15 equals ror 1", 3'd4, 16'h8001, 8'd15);
    chk("R7 ror 1 value", 32'(out_data), 32'h0000C000);
    xfer("R7 rol 16 wraps to 0", 3'd4, 16'h1234, 8'd16);
    chk("R7 rol 16 value", 32'(out_data), 32'h00001234);
    xfer("R7 rol high bits ignored", 3'd4, 16'h00F0, 8'hF4);
  endtask

  task automatic t_reserved;
    xfer("R8 mode 5", 3'd5, 16'hBEEF, 8'd7);
    xfer("R8 mode 7", 3'd7, 16'h1357, 8'd1);
  endtask

  // Back-to-back requests with the consumer always ready.
  task automatic t_stream;
    logic [15:0] d[4] = '{16'h0F0F, 16'h8000, 16'h1111, 16'hC001};
    logic [2:0]  m[4] = '{3'd0, 3'd1, 3'd3, 3'd4};
    logic [7:0]  c[4] = '{8'd4, 8'd2, 8'd1, 8'd2};
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk("R11 stream valid", 32'(out_valid), 32'd1);
        chk("R11 stream data", 32'(out_data),
            32'(model(m[k-1], d[k-1], c[k-1])));
        chk("R9 stream count", 32'(out_cnt), 32'(c[k-1]));
      end
      in_valid = 1'b1;
      in_mode  = m[k];
      in_data  = d[k];
      in_cnt   = c[k];
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 stream last", 32'(out_data), 32'(model(m[3], d[3], c[3])));
    @(negedge clk);
    chk("R11 drained idle", 32'(out_valid), 32'd0);
  endtask

  // Stall with a waiting request, then drain and accept on one edge.
  task automatic t_backpressure;
    logic [15:0] exp_a = model(3'd0, 16'h00FF, 8'd4);
    logic [15:0] exp_b = model(3'd2, 16'hF0F0, 8'd8);
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_mode   = 3'd0;
    in_data   = 16'h00FF;
    in_cnt    = 8'd4;
    @(negedge clk);
    chk("R11 first held valid", 32'(out_valid), 32'd1);
    chk("R11 first data", 32'(out_data), 32'(exp_a));
    chk("R11 blocked ready", 32'(in_ready), 32'd0);
    in_mode = 3'd2;
    in_data = 16'hF0F0;
    in_cnt  = 8'd8;
    repeat (2) @(negedge clk);
    chk("R11 held data under stall", 32'(out_data), 32'(exp_a));
    chk("R11 held count under stall", 32'(out_cnt), 32'd4);
    chk("R11 still blocked", 32'(in_ready), 32'd0);
    out_ready = 1'b1;
    #1;
    chk("R11 ready follows out_ready", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 drain+accept valid", 32'(out_valid), 32'd1);
    chk("R11 drain+accept data", 32'(out_data), 32'(exp_b));
    chk("R9 drain+accept count", 32'(out_cnt), 32'd8);
    @(negedge clk);
    chk("R11 empty after drain", 32'(out_valid), 32'd0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_shl();
    t_sra();
    t_srl();
    t_srf();
    t_high_bits();
    t_rotate();
    t_reserved();
    t_stream();
    t_backpressure();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule